// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

The block keeps a time of day (hours, minutes, seconds) and a calendar date (day of month, month, two-digit year) as packed BCD digits and advances them once per calendar second. Seconds are derived from a slow tick pulse, nominally 32768 per second. The tick passes through two chained dividers: a fine divider and a coarse divider, both with programmable reload values. The calendar advances when both dividers wrap in the same tick. The year field covers 00 to 99, which stands for 2000 to 2099. A year that divides by 4 is therefore always a leap year.

Software sets the clock by raising an initialisation request and waiting for the acknowledge. While the acknowledge is high the calendar and dividers are frozen, and time and date words may be written. When the request drops, counting resumes from the written values and a whole second starts from zero.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word is 0 (00:00:00, flag bit 0), the date word encodes year 00, month 01, day 01, and init_ack_o and inited_o are 0.
- R2: With fine reload A and coarse reload S, the calendar advances by one second on every (A+1)*(S+1)-th tick_i pulse. With A=127 and S=255 that is every 32768 pulses.
- R3: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the day.
- R4: The day wraps to 01 after the last day of its month, with a carry into the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02. Month 02 ends on 29 when the binary year value is divisible by 4, and on 28 otherwise.
- R5: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R6: init_ack_o goes high on the first clock edge that samples init_req_i high, and goes low on the first edge that samples it low. While init_ack_o is high, tick_i pulses do not change the time or date.
- R7: A wr_time_i or wr_date_i strobe with init_ack_o high loads wdata_i, and the new value is visible on the outputs after that edge. With init_ack_o low the strobes have no effect.
- R8: Both dividers are held at zero during initialisation. The first second after init_ack_o falls therefore arrives exactly (A+1)*(S+1) tick pulses later.
- R9: inited_o rises at the first accepted write and stays high until reset.
- R10: The time word layout is [20] PM flag (stored as written, 0 for 24-hour), [19:18] hour tens, [17:14] hour units, [13:11] minute tens, [10:7] minute units, [6:4] second tens, [3:0] second units. The date word layout is [18:15] year tens, [14:11] year units, [10] month tens, [9:6] month units, [5:4] day tens, [3:0] day units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle tick pulse from the slow time base |
| async_div_i | input | AW | Fine divider reload value A |
| sync_div_i | input | SW | Coarse divider reload value S |
| init_req_i | input | 1 | Initialisation request (level) |
| init_ack_o | output | 1 | Initialisation mode active, writes allowed |
| inited_o | output | 1 | Calendar loaded since reset |
| wr_time_i | input | 1 | Time word write strobe |
| wr_date_i | input | 1 | Date word write strobe |
| wdata_i | input | 21 | Write data; the date uses bits [18:0] |
| time_o | output | 21 | Packed BCD time word |
| date_o | output | 19 | Packed BCD date word |

## Verification
The hardest situation to reach from the ports is a chain of carries across every field, such as 23:59:59 on the last day of February, or on 31 December of year 99. At the nominal rate each second costs 32768 ticks. The stimulus therefore loads states one second before such boundaries through the initialisation handshake and runs the dividers at small reload values. It mixes directed year-end and leap-year dates with random dates near month ends, and it uses random gaps between ticks. The nominal 32768-tick period is measured once on its own.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int TIME_W = 21;
  localparam int DATE_W = 19;

  // two-digit BCD increment, no range check
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int bcd_bin(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  // last day of month, in BCD
  function automatic logic [7:0] last_day(input logic [7:0] mo, input logic [7:0] yr);
    int m;
    m = bcd_bin(mo);
    if (m == 2) return ((bcd_bin(yr) % 4) == 0) ? 8'h29 : 8'h28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 8'h30;
    return 8'h31;
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int AW = 7,
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          freeze_i,
  input  logic [AW-1:0] a_div_i,
  input  logic [SW-1:0] s_div_i,
  output logic          sec_en_o
);
  logic [AW-1:0] a_cnt;
  logic [SW-1:0] s_cnt;
  logic a_wrap, s_wrap;

  assign a_wrap   = (a_cnt >= a_div_i);
  assign s_wrap   = (s_cnt >= s_div_i);
  assign sec_en_o = tick_i && !freeze_i && a_wrap && s_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cnt <= '0;
      s_cnt <= '0;
    end else if (freeze_i) begin
      a_cnt <= '0;
      s_cnt <= '0;
    end else if (tick_i) begin
      if (a_wrap) begin
        a_cnt <= '0;
        s_cnt <= s_wrap ? '0 : s_cnt + 1'b1;
      end else begin
        a_cnt <= a_cnt + 1'b1;
      end
    end
  end

  a_r8_frozen_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> (a_cnt == '0 && s_cnt == '0));
  a_r2_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_en_o |=> (a_cnt == '0 && s_cnt == '0));
endmodule

// File: rtl/cal_clock.sv
module cal_clock
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [TIME_W-1:0] ld_val_i,
  output logic [TIME_W-1:0] time_o,
  output logic              day_cy_o
);
  logic [7:0] sec_q, min_q, hr_q;
  logic       pm_q;
  logic       sec_top, min_top, hr_top;

  assign sec_top  = (sec_q == 8'h59);
  assign min_top  = (min_q == 8'h59);
  assign hr_top   = (hr_q == 8'h23);
  assign day_cy_o = en_i && !ld_i && sec_top && min_top && hr_top;
  assign time_o   = {pm_q, hr_q[5:0], min_q[6:0], sec_q[6:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      pm_q  <= 1'b0;
    end else if (ld_i) begin
      pm_q  <= ld_val_i[20];
      hr_q  <= {2'b0, ld_val_i[19:14]};
      min_q <= {1'b0, ld_val_i[13:7]};
      sec_q <= {1'b0, ld_val_i[6:0]};
    end else if (en_i) begin
      sec_q <= sec_top ? 8'h00 : bcd_inc(sec_q);
      if (sec_top) begin
        min_q <= min_top ? 8'h00 : bcd_inc(min_q);
        if (min_top) hr_q <= hr_top ? 8'h00 : bcd_inc(hr_q);
      end
    end
  end

  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && sec_top) |=> (sec_q == 8'h00));
  a_r3_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !(en_i && sec_top)) |=> $stable(min_q));
endmodule

// File: rtl/cal_date.sv
module cal_date
  import cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [DATE_W-1:0] ld_val_i,
  output logic [DATE_W-1:0] date_o
);
  logic [7:0] yr_q, mo_q, dy_q;
  logic       dy_top, mo_top, yr_top;

  assign dy_top = (dy_q == last_day(mo_q, yr_q));
  assign mo_top = (mo_q == 8'h12);
  assign yr_top = (yr_q == 8'h99);
  assign date_o = {yr_q, mo_q[4:0], dy_q[5:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yr_q <= 8'h00;
      mo_q <= 8'h01;
      dy_q <= 8'h01;
    end else if (ld_i) begin
      yr_q <= ld_val_i[18:11];
      mo_q <= {3'b0, ld_val_i[10:6]};
      dy_q <= {2'b0, ld_val_i[5:0]};
    end else if (en_i) begin
      dy_q <= dy_top ? 8'h01 : bcd_inc(dy_q);
      if (dy_top) begin
        mo_q <= mo_top ? 8'h01 : bcd_inc(mo_q);
        if (mo_top) yr_q <= yr_top ? 8'h00 : bcd_inc(yr_q);
      end
    end
  end

  a_r5_year_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && yr_top && mo_top && dy_q == 8'h31)
      |=> (yr_q == 8'h00 && mo_q == 8'h01 && dy_q == 8'h01));
  a_r4_feb_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i && mo_q == 8'h02 && dy_q == 8'h29) |=> (mo_q == 8'h03 && dy_q == 8'h01));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int AW = 7,
  parameter int SW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [AW-1:0]     async_div_i,
  input  logic [SW-1:0]     sync_div_i,
  input  logic              init_req_i,
  output logic              init_ack_o,
  output logic              inited_o,
  input  logic              wr_time_i,
  input  logic              wr_date_i,
  input  logic [TIME_W-1:0] wdata_i,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o
);
  logic mode_q, inited_q;
  logic sec_en, day_cy, ld_time, ld_date;

  assign ld_time    = wr_time_i && mode_q;
  assign ld_date    = wr_date_i && mode_q;
  assign init_ack_o = mode_q;
  assign inited_o   = inited_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      inited_q <= 1'b0;
    end else begin
      mode_q <= init_req_i;
      if (ld_time || ld_date) inited_q <= 1'b1;
    end
  end

  cal_prescaler #(.AW(AW), .SW(SW)) u_presc (
    .clk_i, .rst_ni, .tick_i,
    .freeze_i (mode_q),
    .a_div_i  (async_div_i),
    .s_div_i  (sync_div_i),
    .sec_en_o (sec_en)
  );

  cal_clock u_clock (
    .clk_i, .rst_ni,
    .en_i     (sec_en),
    .ld_i     (ld_time),
    .ld_val_i (wdata_i),
    .time_o   (time_o),
    .day_cy_o (day_cy)
  );

  cal_date u_date (
    .clk_i, .rst_ni,
    .en_i     (day_cy),
    .ld_i     (ld_date),
    .ld_val_i (wdata_i[DATE_W-1:0]),
    .date_o   (date_o)
  );

  a_r6_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_req_i |=> init_ack_o);
  a_r6_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_ack_o && !wr_time_i && !wr_date_i) |=> ($stable(time_o) && $stable(date_o)));
  a_r7_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_ack_o && !sec_en) |=> ($stable(time_o) && $stable(date_o)));
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inited_o |=> inited_o);
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [6:0]  adiv = 7'd3;
  logic [7:0]  sdiv = 8'd1;
  logic        req = 1'b0, wr_t = 1'b0, wr_d = 1'b0;
  logic [20:0] wdata = '0;
  logic        ack, inited;
  logic [20:0] time_w;
  logic [18:0] date_w;
  int total = 0, bad = 0;
  int h, m, s, y, mo, d;

  always #10 clk = ~clk;

  bcd_calendar u_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .async_div_i(adiv), .sync_div_i(sdiv),
    .init_req_i(req), .init_ack_o(ack), .inited_o(inited),
    .wr_time_i(wr_t), .wr_date_i(wr_d), .wdata_i(wdata),
    .time_o(time_w), .date_o(date_w)
  );

  function automatic logic [20:0] pk_t(int hh, int mm, int ss);
    return {1'b0, 2'(hh / 10), 4'(hh % 10), 3'(mm / 10), 4'(mm % 10), 3'(ss / 10), 4'(ss % 10)};
  endfunction
  function automatic logic [18:0] pk_d(int yy, int mm, int dd);
    return {4'(yy / 10), 4'(yy % 10), 1'(mm / 10), 4'(mm % 10), 2'(dd / 10), 4'(dd % 10)};
  endfunction
  function automatic int dim(int yy, int mm);
    if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
    if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
    return 31;
  endfunction

  task automatic adv_model();
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) begin h = 0; d++; end
    if (d > dim(y, mo)) begin d = 1; mo++; end
    if (mo == 13) begin mo = 1; y++; end
    if (y == 100) y = 0;
  endtask

  task automatic chk(string req_id, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req_id, act, exp);
    end
  endtask

  task automatic chk_model(string req_id);
    chk(req_id, 32'(time_w), 32'(pk_t(h, m, s)));
    chk(req_id, 32'(date_w), 32'(pk_d(y, mo, d)));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic load(int hh, int mm, int ss, int yy, int mn, int dd);
    @(negedge clk) req = 1'b1;
    @(negedge clk);
    chk("R6 ack rise", 32'(ack), 32'd1);
    wr_t = 1'b1; wdata = pk_t(hh, mm, ss);
    @(negedge clk) wr_t = 1'b0;
    wr_d = 1'b1; wdata = {2'b0, pk_d(yy, mn, dd)};
    @(negedge clk) wr_d = 1'b0;
    req = 1'b0;
    @(negedge clk);
    chk("R6 ack fall", 32'(ack), 32'd0);
    h = hh; m = mm; s = ss; y = yy; mo = mn; d = dd;
  endtask

  // run n seconds at divider period per; first second checked for early advance
  task automatic run_secs(int n, int per, string req_id);
    for (int k = 0; k < n; k++) begin
      ticks(per - 1);
      if (k == 0) chk_model("R8 no early second");
      ticks(1);
      adv_model();
      chk_model(req_id);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 time", 32'(time_w), 32'd0);
    chk("R1 date", 32'(date_w), 32'(pk_d(0, 1, 1)));
    chk("R1 ack", 32'(ack), 32'd0);
    chk("R9 inited at reset", 32'(inited), 32'd0);
    rst_n = 1'b1;

    // R7 write outside init ignored
    @(negedge clk) wr_t = 1'b1; wr_d = 1'b1; wdata = pk_t(12, 34, 56);
    @(negedge clk) wr_t = 1'b0; wr_d = 1'b0;
    chk("R7 ignored time", 32'(time_w), 32'd0);
    chk("R7 ignored date", 32'(date_w), 32'(pk_d(0, 1, 1)));
    chk("R9 not set by ignored write", 32'(inited), 32'd0);

    // R7/R9/R10 load
    load(12, 34, 56, 23, 7, 15);
    chk_model("R10 loaded layout");
    chk("R9 inited set", 32'(inited), 32'd1);

    // R6 frozen during init
    @(negedge clk) req = 1'b1;
    ticks(20);
    chk_model("R6 frozen");
    @(negedge clk) req = 1'b0;
    @(negedge clk);
    run_secs(2, 8, "R2 advance");

    // directed rollovers, A=3 S=1 -> 8 ticks
    load(23, 59, 59, 23, 2, 28); run_secs(1, 8, "R4 feb non-leap");
    load(23, 59, 59, 24, 2, 28); run_secs(1, 8, "R4 feb leap 28");
    load(23, 59, 59, 24, 2, 29); run_secs(1, 8, "R4 feb leap 29");
    load(23, 59, 59, 0, 2, 28);  run_secs(1, 8, "R4 year 00 leap");
    load(23, 59, 59, 50, 4, 30); run_secs(1, 8, "R4 30-day month");
    load(23, 59, 59, 99, 12, 31); run_secs(2, 8, "R5 year wrap");
    load(9, 59, 58, 10, 1, 9);   run_secs(3, 8, "R3 bcd carry");

    // other divider A=1 S=2 -> 6 ticks
    adiv = 7'd1; sdiv = 8'd2;
    load(19, 59, 59, 45, 9, 30); run_secs(2, 6, "R2 alt divider");
    adiv = 7'd3; sdiv = 8'd1;

    // random dates near boundaries
    for (int it = 0; it < 30; it++) begin
      int ry, rm, rd;
      ry = $urandom % 100; rm = 1 + $urandom % 12;
      rd = dim(ry, rm) - ($urandom % 2);
      load(22 + $urandom % 2, 58 + $urandom % 2, 55 + $urandom % 5, ry, rm, rd);
      run_secs(1 + $urandom % 4, 8, "R3 R4 R5 random");
    end

    // R2 nominal 32768-tick second
    load(0, 0, 0, 1, 1, 1);
    adiv = 7'd127; sdiv = 8'd255;
    @(negedge clk) tick = 1'b1;
    repeat (32767) @(negedge clk);
    chk_model("R2 nominal no early second");
    @(negedge clk) tick = 1'b0;
    adv_model();
    chk_model("R2 nominal second");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule